// File: doc/BRIEF.md
# Segment-Based Logical Address Translator

This block turns a logical address into a 32-bit linear address. A logical address is a 16-bit selector plus a 32-bit offset. A selector bit chooses one of two descriptor tables. The block computes where the 8-byte descriptor sits in that table and reads it over a simple 64-bit request/acknowledge port. It then puts the scattered base and limit fields back together and checks the entry. If every check passes, it adds the offset to the base.

A caller presents the selector, the offset and the current privilege level, then pulses `start`. One translation runs at a time. When it finishes, `done` pulses for one cycle. In that cycle `fault` holds the outcome and `lin_addr` holds the address. Both keep their values until the next completion.

Fault codes:

| Code | Meaning |
|------|---------|
| 0 | Success |
| 1 | Null selector |
| 2 | Segment not present |
| 3 | Offset beyond the limit |
| 4 | Privilege violation |

Top module: `seg_xlate`

## Requirements
- R1: The selector is split as follows. Bits 15..3 are the entry index and bit 2 chooses the table: 0 selects `gtab_base`, 1 selects `ltab_base`. The descriptor read goes to the chosen base plus index*8, and `mem_addr` stays stable while the read is pending.
- R2: A selector whose bits 15..2 are all zero is null. It completes with fault 1 and `done` high one cycle after `start` is sampled. No memory request is made. Index 0 with bit 2 set is not null.
- R3: On success, `fault` is 0 and `lin_addr` is the descriptor base plus the offset, modulo 2^32. The base is bits 63..56 (high byte) joined with bits 39..16 (low 24 bits).
- R4: The 20-bit limit is bits 51..48 (high) joined with bits 15..0. With bit 55 clear the limit counts bytes. An offset equal to the limit passes; a larger offset gives fault 3.
- R5: With bit 55 set, the effective limit is the 20-bit limit followed by twelve one bits (4 KB granules).
- R6: A clear bit 47 (present) gives fault 2. This takes precedence over the privilege and limit faults.
- R7: A data segment has bit 44 set and bit 43 clear. For such a segment, fault 4 is raised when the larger of `cpl` and the selector's bits 1..0 exceeds the descriptor privilege in bits 46..45. Code segments skip this check. The privilege fault takes precedence over the limit fault.
- R8: `mem_req` rises the cycle after `start` is sampled and is held until `mem_ack`. `done` is low in the cycle after the acknowledge and high for exactly one cycle after that.
- R9: `start` is ignored while a translation is in progress and in the cycle where `done` is high.
- R10: After reset, `done`, `mem_req`, `fault` and `lin_addr` are all zero.
- R11: When `fault` is non-zero at completion, `lin_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation |
| selector | input | 16 | Segment selector |
| offset | input | 32 | Offset within the segment |
| cpl | input | 2 | Current privilege level (0 = most privileged) |
| gtab_base | input | 32 | Global descriptor table base |
| ltab_base | input | 32 | Local descriptor table base |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor contents |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 3 | Outcome code |
| lin_addr | output | 32 | Linear address |

## Verification
The bench places offsets exactly on the byte limit and on the granular limit, and one past each. A design that uses `>=` for the comparison, or that leaves out the twelve low one bits, faults on a legal offset or accepts an illegal one.

Several descriptors carry more than one problem at once, to show which fault wins. A design with the wrong precedence reports the wrong code.

Other cases target specific mistakes:
- A base plus offset that wraps past 2^32 catches truncation errors.
- Index 0 in the local table catches a null test that ignores the table bit.
- A code segment with low privilege catches a privilege check that is not limited to data segments.
- A `start` pulse raised in mid-fetch, and another in the completion cycle, catch a design that restarts, or that issues a request when it should not.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int DESC_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] selector,
  input  logic [31:0] offset,
  input  logic [1:0]  cpl,
  input  logic [31:0] gtab_base,
  input  logic [31:0] ltab_base,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata,
  output logic        done,
  output logic [2:0]  fault,
  output logic [31:0] lin_addr
);
  localparam int SHIFT = $clog2(DESC_BYTES);
  localparam logic [2:0] F_OK = 3'd0, F_NULL = 3'd1, F_NP = 3'd2, F_LIM = 3'd3, F_PRIV = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EVAL} st_t;
  st_t st;

  logic [1:0]  rpl_q, cpl_q;
  logic [31:0] off_q;
  logic [63:0] desc_q;
  logic        done_q;
  logic [2:0]  fault_q;
  logic [31:0] lin_q, addr_q;

  wire        is_null  = (selector[15:2] == 14'd0);
  wire [31:0] tbl_base = selector[2] ? ltab_base : gtab_base;
  wire [31:0] idx_off  = {{(19 - SHIFT){1'b0}}, selector[15:3]} << SHIFT;

  wire [31:0] seg_base = {desc_q[63:56], desc_q[39:16]};
  wire [19:0] lim20    = {desc_q[51:48], desc_q[15:0]};
  wire [31:0] eff_lim  = desc_q[55] ? {lim20, 12'hFFF} : {12'h000, lim20};
  wire        present  = desc_q[47];
  wire [1:0]  dpl      = desc_q[46:45];
  wire        is_data  = desc_q[44] & ~desc_q[43];
  wire [1:0]  eff_pl   = (cpl_q > rpl_q) ? cpl_q : rpl_q;

  logic [2:0] verdict;
  always_comb begin
    if (!present)                    verdict = F_NP;
    else if (is_data && eff_pl > dpl) verdict = F_PRIV;
    else if (off_q > eff_lim)        verdict = F_LIM;
    else                             verdict = F_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rpl_q   <= '0;
      cpl_q   <= '0;
      off_q   <= '0;
      desc_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= F_OK;
      lin_q   <= '0;
      addr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start && !done_q) begin
          rpl_q <= selector[1:0];
          cpl_q <= cpl;
          off_q <= offset;
          if (is_null) begin
            done_q  <= 1'b1;
            fault_q <= F_NULL;
            lin_q   <= '0;
          end else begin
            addr_q <= tbl_base + idx_off;
            st     <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack) begin
          desc_q <= mem_rdata;
          st     <= S_EVAL;
        end
        default: begin
          done_q  <= 1'b1;
          fault_q <= verdict;
          lin_q   <= (verdict == F_OK) ? seg_base + off_q : 32'd0;
          st      <= S_IDLE;
        end
      endcase
    end
  end

  assign mem_req  = (st == S_FETCH);
  assign mem_addr = addr_q;
  assign done     = done_q;
  assign fault    = fault_q;
  assign lin_addr = lin_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [15:0] selector,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        done,
  input logic [2:0]  fault,
  input logic [31:0] lin_addr
);
  // R1
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr));
  // R2
  null_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mem_req && !done && selector[15:2] == 14'd0 |=> !mem_req);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req);
  // R8
  ack_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !done ##1 done);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  fault_lin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault != 3'd0 |-> lin_addr == 32'd0);
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic clk = 0, rst_n = 0, start = 0, mem_ack = 0;
  logic [15:0] selector = 0;
  logic [31:0] offset = 0;
  logic [1:0]  cpl = 0;
  logic [63:0] mem_rdata = 0;
  logic        mem_req, done;
  logic [31:0] mem_addr, lin_addr;
  logic [2:0]  fault;
  localparam logic [31:0] GT = 32'h0010_0000, LT = 32'h0020_0000;

  always #5 clk = ~clk;

  seg_xlate u_dut (.clk, .rst_n, .start, .selector, .offset, .cpl,
    .gtab_base(GT), .ltab_base(LT), .mem_req, .mem_addr, .mem_ack,
    .mem_rdata, .done, .fault, .lin_addr);

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l, input logic g, input logic p,
                                     input logic [1:0] dpl, input logic s, input logic [3:0] ty);
    return {b[31:24], g, 1'b1, 1'b0, 1'b0, l[19:16], p, dpl, s, ty, b[23:0], l[15:0]};
  endfunction

  typedef struct packed {
    logic [15:0] sel; logic [31:0] off; logic [1:0] cpl;
    logic [63:0] desc; logic [2:0] fault; logic [31:0] lin;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0028, 32'h100,  2'd0, mk(32'h12345678, 20'hFFFFF, 0, 1, 2'd0, 1, 4'h2), 3'd0, 32'h12345778}, // R1 R3
    '{16'h001C, 32'h200,  2'd0, mk(32'hFFFFFF00, 20'hFFFFF, 0, 1, 2'd0, 1, 4'h2), 3'd0, 32'h00000100}, // R1 R3 wrap
    '{16'h0010, 32'hFFF,  2'd0, mk(32'h00001000, 20'h00FFF, 0, 1, 2'd0, 1, 4'h2), 3'd0, 32'h00001FFF}, // R4 equal
    '{16'h0018, 32'h1000, 2'd0, mk(32'h00001000, 20'h00FFF, 0, 1, 2'd0, 1, 4'h2), 3'd3, 32'h0},        // R4 over
    '{16'h0020, 32'h1FFF, 2'd0, mk(32'h40000000, 20'h00001, 1, 1, 2'd0, 1, 4'h2), 3'd0, 32'h40001FFF}, // R5 equal
    '{16'h0030, 32'h2000, 2'd0, mk(32'h40000000, 20'h00001, 1, 1, 2'd0, 1, 4'h2), 3'd3, 32'h0},        // R5 over
    '{16'h0040, 32'h5000, 2'd3, mk(32'h00000000, 20'h00FFF, 0, 0, 2'd0, 1, 4'h2), 3'd2, 32'h0},        // R6
    '{16'h0008, 32'h10,   2'd3, mk(32'h00000000, 20'hFFFFF, 0, 1, 2'd0, 1, 4'h2), 3'd4, 32'h0},        // R7 cpl
    '{16'h003B, 32'h10,   2'd0, mk(32'h00005000, 20'hFFFFF, 0, 1, 2'd3, 1, 4'h2), 3'd0, 32'h00005010}, // R7 ok
    '{16'h004A, 32'h100,  2'd0, mk(32'h00000000, 20'h00010, 0, 1, 2'd1, 1, 4'h2), 3'd4, 32'h0},        // R7 rpl
    '{16'h0050, 32'h44,   2'd3, mk(32'h00300000, 20'hFFFFF, 0, 1, 2'd0, 1, 4'hA), 3'd0, 32'h00300044}, // R7 code
    '{16'h0004, 32'hABC,  2'd0, mk(32'h00000000, 20'hFFFFF, 0, 1, 2'd0, 1, 4'h2), 3'd0, 32'h00000ABC}, // R2 not null
    '{16'h0003, 32'h0,    2'd0, 64'h0,                                             3'd1, 32'h0}         // R2 null
  };

  task automatic xlate(input vec_t v, input int dly, input bit poke);
    logic [31:0] ea;
    ea = (v.sel[2] ? LT : GT) + {16'h0, v.sel[15:3], 3'b000};
    @(negedge clk);
    selector = v.sel; offset = v.off; cpl = v.cpl; start = 1;
    @(negedge clk);
    start = 0;
    if (v.fault == 3'd1) begin
      chk(done === 1'b1, "R2 null done", done, 1);
      chk(fault === 3'd1, "R2 null fault", fault, 1);
      chk(mem_req === 1'b0, "R2 null no request", mem_req, 0);
      @(negedge clk);
      chk(done === 1'b0, "R8 null pulse", done, 0);
      return;
    end
    chk(mem_req === 1'b1, "R8 request raised", mem_req, 1);
    chk(mem_addr === ea, "R1 descriptor address", mem_addr, ea);
    for (int i = 0; i < dly; i++) begin
      if (poke && i == 0) begin selector = 16'h0003; start = 1; end
      @(negedge clk);
      start = 0;
      chk(mem_req === 1'b1, "R8 request held", mem_req, 1);
    end
    if (poke) chk(mem_addr === ea, "R9 address unchanged", mem_addr, ea);
    mem_rdata = v.desc; mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
    chk(done === 1'b0 && mem_req === 1'b0, "R8 gap after ack", {done, mem_req}, 0);
    @(negedge clk);
    chk(done === 1'b1, "R8 done", done, 1);
    chk(fault === v.fault, "R3-R7 fault code", fault, v.fault);
    chk(lin_addr === v.lin, "R3 R11 linear address", lin_addr, v.lin);
    @(negedge clk);
    chk(done === 1'b0, "R8 done pulse", done, 0);
    chk(fault === v.fault && lin_addr === v.lin, "R3 outputs held", lin_addr, v.lin);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 0 && mem_req === 0 && fault === 0 && lin_addr === 0, "R10 reset state",
        {done, mem_req, fault, lin_addr}, 0);
    rst_n = 1;
    for (int k = 0; k < NV; k++) xlate(VECS[k], k % 3, 1'b0);

    // R9: start pulsed during fetch is ignored
    xlate(VECS[0], 2, 1'b1);

    // R9: start in the done cycle is ignored
    @(negedge clk);
    selector = 16'h0028; offset = 32'h100; cpl = 0; start = 1;
    @(negedge clk);
    start = 0;
    mem_rdata = VECS[0].desc; mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
    @(negedge clk);
    chk(done === 1'b1, "R9 setup done", done, 1);
    selector = 16'h0003; start = 1;
    @(negedge clk);
    start = 0;
    chk(done === 1'b0 && mem_req === 1'b0, "R9 start during done ignored", {done, mem_req}, 0);
    chk(fault === 3'd0 && lin_addr === 32'h12345778, "R9 result kept", lin_addr, 32'h12345778);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule